// File: doc/BRIEF.md
# Interlaced Field DMA Address Generator

This block produces the destination byte address for video write DMA into host memory, one interlaced field at a time. Software programs a top-field base, a bottom-field base and a line stride through a small write port. When a field begins, the block loads its running address from the base that matches the field parity. Each accepted doubleword moves the address forward by four bytes. At the end of each line the stride moves the address to the start of the next line.

A display-mode input selects how the stride is read. In mode 1 the stride is the gap in bytes between the last doubleword of a line and the first doubleword of the next line. In mode 0 the stride is the full distance from the start of one line to the start of the next. The programmed values are copied into the working set only at a field start, so a field always uses one consistent set of values. The bus master and pixel formatting sit outside this block.

Top module: `fdma_field_addr_gen`

## Requirements
- R1: After synchronous reset, `dma_addr` is 0xFFFFFFFC. Both programmed bases are 0xFFFFFFFC and the stride is 0xFFFC.
- R2: A write selects its target with `cfg_sel`: 0 is the top base, 1 is the bottom base and 2 is the stride. Bits 1:0 of the written value are stored as zero. The stride keeps only bits 15:0 of `cfg_data`.
- R3: In a cycle with `field_start` high, the next `dma_addr` is the programmed top base when `field_odd` is 0 and the programmed bottom base when `field_odd` is 1.
- R4: In a cycle with `word_ack` high and neither `field_start` nor `line_end` high, `dma_addr` increases by 4 with wrap modulo 2^32.
- R5: With `disp_mode` = 1, `line_end` moves `dma_addr` to the last accepted doubleword's address plus 4 plus the stride. With contiguous lines this is the stride-zero case.
- R6: With `disp_mode` = 0, `line_end` moves `dma_addr` to the address the current line started at plus the stride. With contiguous lines the stride equals the line size in bytes.
- R7: When `word_ack` and `line_end` are high in the same cycle, that doubleword is counted as the last one of the line before the line-end step is applied.
- R8: Base and stride writes take effect only at the next `field_start`. During a field, line steps use the stride captured at that field's start. A write in the same cycle as `field_start` is not used by that field start.
- R9: `field_start` takes priority over `line_end` and `word_ack` in the same cycle.
- R10: With no strobe high, `dma_addr` holds its value. A write with `cfg_sel` = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 top base, 1 bottom base, 2 stride, 3 none |
| cfg_data | input | 32 | Write data |
| field_start | input | 1 | Start of a field |
| field_odd | input | 1 | Field parity: 0 top, 1 bottom |
| line_end | input | 1 | End of a display line |
| word_ack | input | 1 | One doubleword accepted by the bus |
| disp_mode | input | 1 | Stride meaning: 1 gap after the last word, 0 line-to-line pitch |
| dma_addr | output | 32 | Current doubleword-aligned destination byte address |

## Verification
The address sequence is compared against a behavioural model on every cycle. Multi-line fields are run in both display modes and with both field parities. Equal line lengths with different strides separate the mode 1 arithmetic (based on the last word) from the mode 0 arithmetic (based on the line start). Unaligned and over-wide write data show that the low bits are masked and that the stride is truncated. Writes placed in the middle of a field, and in the same cycle as a field start, show whether shadowing happens at the right moment. Coincident strobes and a base of 0xFFFFFFFC exercise the priority order, the last-word merge and the 32-bit wrap.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
    localparam int ADDR_W   = 32;
    localparam int STRIDE_W = 16;
    localparam int ALIGN_W  = 2;
    localparam int STEP     = 1 << ALIGN_W;

    typedef enum logic [1:0] {
        SEL_TOP    = 2'd0,
        SEL_BOT    = 2'd1,
        SEL_STRIDE = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0]   top;
        logic [ADDR_W-1:0]   bot;
        logic [STRIDE_W-1:0] stride;
    } cfg_t;

    function automatic logic [ADDR_W-1:0] align_addr(input logic [ADDR_W-1:0] v);
        return {v[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    endfunction

    function automatic logic [STRIDE_W-1:0] align_stride(input logic [STRIDE_W-1:0] v);
        return {v[STRIDE_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    endfunction
endpackage

// File: rtl/fdma_cfg_regs.sv
module fdma_cfg_regs
    import fdma_pkg::*;
#(
    parameter logic [ADDR_W-1:0]   RESET_BASE   = 32'hFFFF_FFFC,
    parameter logic [STRIDE_W-1:0] RESET_STRIDE = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              field_start,
    output cfg_t              prog,
    output cfg_t              active
);
    localparam cfg_t CFG_RESET = '{top: RESET_BASE, bot: RESET_BASE, stride: RESET_STRIDE};

    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            prog   <= CFG_RESET;
            active <= CFG_RESET;
        end else begin
            if (field_start) begin
                active <= prog;
            end
            if (cfg_we) begin
                case (sel)
                    SEL_TOP:    prog.top    <= align_addr(cfg_data);
                    SEL_BOT:    prog.bot    <= align_addr(cfg_data);
                    SEL_STRIDE: prog.stride <= align_stride(cfg_data[STRIDE_W-1:0]);
                    default:    ;
                endcase
            end
        end
    end

    // R8: working set changes only at a field start
    a_r8_active_hold: assert property (@(posedge clk) disable iff (rst)
        !field_start |=> $stable(active));

    // R10: selector 3 leaves the programmed set alone
    a_r10_sel_none: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd3) |=> $stable(prog));
endmodule

// File: rtl/fdma_addr_core.sv
module fdma_addr_core
    import fdma_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_BASE = 32'hFFFF_FFFC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                field_start,
    input  logic                field_odd,
    input  logic                line_end,
    input  logic                word_ack,
    input  logic                disp_mode,
    input  logic [ADDR_W-1:0]   base_top,
    input  logic [ADDR_W-1:0]   base_bot,
    input  logic [STRIDE_W-1:0] stride,
    output logic [ADDR_W-1:0]   addr
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] cur_q, line_q;
    logic [ADDR_W-1:0] end_addr, stride_ext, next_line, field_base;

    always_comb begin
        stride_ext = {{(ADDR_W-STRIDE_W){1'b0}}, stride};
        end_addr   = word_ack ? cur_q + STEP_V : cur_q;
        next_line  = disp_mode ? end_addr + stride_ext : line_q + stride_ext;
        field_base = field_odd ? base_bot : base_top;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= RESET_BASE;
            line_q <= RESET_BASE;
        end else if (field_start) begin
            cur_q  <= field_base;
            line_q <= field_base;
        end else if (line_end) begin
            cur_q  <= next_line;
            line_q <= next_line;
        end else if (word_ack) begin
            cur_q  <= cur_q + STEP_V;
        end
    end

    assign addr = cur_q;

    // R1: output always doubleword aligned
    a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
        addr[ALIGN_W-1:0] == '0);

    // R4: plain word step
    a_r4_word_step: assert property (@(posedge clk) disable iff (rst)
        (word_ack && !field_start && !line_end) |=> addr == $past(addr) + STEP_V);

    // R3: field load picks base by parity
    a_r3_field_load: assert property (@(posedge clk) disable iff (rst)
        field_start |=> addr == ($past(field_odd) ? $past(base_bot) : $past(base_top)));

    // R10: idle holds
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!field_start && !line_end && !word_ack) |=> $stable(addr));

    // R5: mode 1 with zero stride continues contiguously
    a_r5_contig: assert property (@(posedge clk) disable iff (rst)
        (line_end && !field_start && disp_mode && stride == '0 && !word_ack)
        |=> $stable(addr));
endmodule

// File: rtl/fdma_field_addr_gen.sv
module fdma_field_addr_gen
    import fdma_pkg::*;
#(
    parameter logic [31:0] RESET_BASE   = 32'hFFFF_FFFC,
    parameter logic [15:0] RESET_STRIDE = 16'hFFFC
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_data,
    input  logic        field_start,
    input  logic        field_odd,
    input  logic        line_end,
    input  logic        word_ack,
    input  logic        disp_mode,
    output logic [31:0] dma_addr
);
    cfg_t prog, active;

    fdma_cfg_regs #(
        .RESET_BASE  (RESET_BASE),
        .RESET_STRIDE(RESET_STRIDE)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_data   (cfg_data),
        .field_start(field_start),
        .prog       (prog),
        .active     (active)
    );

    // Bases come from the programmed set as it stands before this cycle's write;
    // the stride in use is the one captured at the field start.
    fdma_addr_core #(
        .RESET_BASE(RESET_BASE)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .field_start(field_start),
        .field_odd  (field_odd),
        .line_end   (line_end),
        .word_ack   (word_ack),
        .disp_mode  (disp_mode),
        .base_top   (prog.top),
        .base_bot   (prog.bot),
        .stride     (active.stride),
        .addr       (dma_addr)
    );

    // R9: field start wins over coincident strobes
    a_r9_priority: assert property (@(posedge clk) disable iff (rst)
        (field_start && (line_end || word_ack))
        |=> dma_addr == ($past(field_odd) ? $past(prog.bot) : $past(prog.top)));
endmodule

// File: tb/test_fdma_field_addr_gen.sv
module test_fdma_field_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd3;
    logic [31:0] cfg_data = '0;
    logic        field_start = 1'b0, field_odd = 1'b0, line_end = 1'b0;
    logic        word_ack = 1'b0, disp_mode = 1'b0;
    logic [31:0] dma_addr;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    bit [31:0] p_top = 32'hFFFF_FFFC, p_bot = 32'hFFFF_FFFC;
    bit [15:0] p_stride = 16'hFFFC, a_stride = 16'hFFFC;
    bit [31:0] m_addr = 32'hFFFF_FFFC, m_line = 32'hFFFF_FFFC;

    always #4 clk = ~clk;

    fdma_field_addr_gen i_fdma_field_addr_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .field_start(field_start), .field_odd(field_odd), .line_end(line_end),
        .word_ack(word_ack), .disp_mode(disp_mode), .dma_addr(dma_addr)
    );

    task automatic check(input string req, input bit [31:0] got, input bit [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: dma_addr actual %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cyc(input bit fs, input bit par, input bit le, input bit wa,
                       input bit mode, input bit we, input bit [1:0] sel, input bit [31:0] d);
        bit [31:0] n_addr, n_line, endv;
        bit [15:0] n_astr;
        field_start = fs; field_odd = par; line_end = le; word_ack = wa;
        disp_mode = mode; cfg_we = we; cfg_sel = sel; cfg_data = d;
        n_addr = m_addr; n_line = m_line; n_astr = a_stride;
        if (fs) begin
            n_addr = par ? p_bot : p_top;
            n_line = n_addr;
            n_astr = p_stride;
        end else if (le) begin
            endv = wa ? m_addr + 32'd4 : m_addr;
            if (mode) n_addr = endv + {16'd0, a_stride};
            else      n_addr = m_line + {16'd0, a_stride};
            n_line = n_addr;
        end else if (wa) begin
            n_addr = m_addr + 32'd4;
        end
        @(posedge clk);
        #1;
        m_addr = n_addr; m_line = n_line; a_stride = n_astr;
        if (we) begin
            if (sel == 2'd0) p_top = d & ~32'd3;
            else if (sel == 2'd1) p_bot = d & ~32'd3;
            else if (sel == 2'd2) p_stride = d[15:0] & ~16'd3;
        end
        check(cur_req, dma_addr, m_addr);
    endtask

    task automatic idle(); cyc(0,0,0,0,disp_mode,0,2'd3,0); endtask
    task automatic wr(input bit [1:0] s, input bit [31:0] d); cyc(0,0,0,0,disp_mode,1,s,d); endtask
    task automatic fstart(input bit par); cyc(1,par,0,0,disp_mode,0,2'd3,0); endtask

    task automatic do_lines(input int nlines, input int nwords, input bit mode, input bit merged);
        for (int l = 0; l < nlines; l++) begin
            for (int w = 0; w < nwords - (merged ? 1 : 0); w++) begin
                cyc(0,0,0,1,mode,0,2'd3,0);
                if (w % 3 == 1) cyc(0,0,0,0,mode,0,2'd3,0);
            end
            cyc(0,0,1,merged,mode,0,2'd3,0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        cur_req = "R1";
        check("R1", dma_addr, 32'hFFFF_FFFC);
        idle();
        fstart(0);
        cur_req = "R4"; cyc(0,0,0,1,0,0,2'd3,0);   // wraps to 0
        check("R4", dma_addr, 32'h0000_0000);
        cur_req = "R1"; fstart(1);
        cyc(0,0,1,0,1,0,2'd3,0);                     // reset stride 0xFFFC in mode 1
        check("R1", dma_addr, 32'hFFFF_FFFC + 32'h0000_FFFC);

        cur_req = "R2";
        wr(2'd0, 32'h1000_0003);
        wr(2'd2, 32'h0001_2347);
        wr(2'd1, 32'h2000_0402);
        fstart(0);
        check("R2", dma_addr, 32'h1000_0000);
        cur_req = "R3"; fstart(1);
        check("R3", dma_addr, 32'h2000_0400);

        cur_req = "R5"; disp_mode = 1;
        wr(2'd2, 32'h100);
        fstart(0);
        do_lines(4, 8, 1, 0);
        check("R5", dma_addr, 32'h1000_0000 + 4*(32 + 256));
        wr(2'd2, 32'h0);
        fstart(1);
        do_lines(3, 5, 1, 0);
        check("R5", dma_addr, 32'h2000_0400 + 60);

        cur_req = "R6"; disp_mode = 0;
        wr(2'd2, 32'h40);
        fstart(0);
        do_lines(3, 8, 0, 0);
        check("R6", dma_addr, 32'h1000_00C0);
        wr(2'd2, 32'h200);
        fstart(1);
        do_lines(3, 6, 0, 0);
        check("R6", dma_addr, 32'h2000_0A00);

        cur_req = "R7";
        fstart(0);
        do_lines(2, 4, 0, 1);
        check("R7", dma_addr, 32'h1000_0400);
        wr(2'd2, 32'h10);
        fstart(1);
        do_lines(2, 4, 1, 1);
        check("R7", dma_addr, 32'h2000_0400 + 2*(16 + 16));

        cur_req = "R8"; disp_mode = 1;
        fstart(0);
        do_lines(1, 2, 1, 0);
        wr(2'd2, 32'h800);
        wr(2'd0, 32'h3000_0000);
        do_lines(1, 2, 1, 0);
        check("R8", dma_addr, 32'h1000_0000 + 2*(8 + 16));
        cyc(1,0,0,0,1,1,2'd0,32'h4000_0000);         // same-cycle write not used
        check("R8", dma_addr, 32'h3000_0000);
        do_lines(1, 2, 1, 0);
        check("R8", dma_addr, 32'h3000_0808);
        fstart(0);
        check("R8", dma_addr, 32'h4000_0000);

        cur_req = "R9";
        cyc(0,0,0,1,1,0,2'd3,0);
        cyc(1,1,1,1,1,0,2'd3,0);
        check("R9", dma_addr, 32'h2000_0400);
        cyc(1,0,0,1,0,0,2'd3,0);
        check("R9", dma_addr, 32'h4000_0000);

        cur_req = "R10";
        repeat (4) idle();
        check("R10", dma_addr, 32'h4000_0000);
        wr(2'd3, 32'h5555_5554);
        fstart(1);
        check("R10", dma_addr, 32'h2000_0400);
        fstart(0);
        check("R10", dma_addr, 32'h4000_0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule